// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block takes a stream of 32-bit trace frames and stores them in an on-chip RAM that is used as a ring. When acquisition is enabled, every presented frame goes into the RAM at the write pointer, and the pointer wraps at the end of the RAM. An external trigger pulse starts a post-trigger countdown. After the trigger, each stored frame lowers a host-loaded counter by one, and when the counter reaches zero the capture stops. The RAM then holds the history around the trigger, and later frames are dropped.

A host reads and writes nine 32-bit registers through a simple addressed port. Reads return data in the same cycle. The registers hold an identification code, the RAM depth and width, a status word, a RAM data window, the read and write pointers, the trigger counter and the control word. Reading the data window returns the word at the read pointer and then moves the pointer on by one, so a host can drain the buffer by setting the read pointer once and reading the data window repeatedly.

Control is a four-state machine. IDLE means not capturing. ARMED means storing frames and waiting for the trigger. POST means storing frames and counting down. DONE means the capture is complete.
- IDLE to ARMED: a control write with bit 0 set.
- ARMED to POST: the trigger fires while the counter is non-zero.
- ARMED to DONE: the trigger fires while the counter is zero.
- POST to DONE: a frame is stored while the counter is 1 or 0.
- Any state to IDLE: a control write with bit 0 clear.
- Any state to ARMED: a control write with bit 0 set, which restarts the capture.

Top module: `trace_ring_capture`

## Requirements
- R1: The host address map is: 0 identification (parameter ID_CODE), 1 RAM depth in frames (parameter DEPTH, default 64), 2 frame width (constant 32), 3 status, 4 RAM data window, 5 read pointer, 6 write pointer, 7 trigger counter, 8 control. Reads are combinational, and unused addresses read 0.
- R2: After reset, status reads 8 (only bit 3 set), both pointers read 0, control reads 0, the trigger counter reads 0 and the state is IDLE.
- R3: A write to control stores bits [1:0], which read back unchanged. Bit 1 is the demultiplexed-mode selector and is held only for readback. Bit 0 set moves the state to ARMED and clears the triggered flag. Bit 0 clear moves the state to IDLE and keeps the other status flags.
- R4: A frame presented with frame_valid is stored only in ARMED or POST. In IDLE or DONE it is dropped, and the write pointer does not change.
- R5: trig_in in ARMED sets status bit 1 (triggered), which stays set until the next enabling control write. trig_in in any other state has no effect.
- R6: A frame presented in the same cycle as the trigger is stored but not counted. In POST, each stored frame decrements the trigger counter (address 7 shows the live value). The frame that takes the counter from 1 to 0 is the last one stored, and status bit 2 (complete) is then set. A trigger while the counter is 0 goes straight to DONE.
- R7: Each stored frame advances the write pointer by one, and the pointer wraps from DEPTH-1 to 0. The first wrap sets status bit 0 (full). Full stays set until the host writes the write pointer, which loads the low pointer bits and clears full.
- R8: A read of address 4 returns the RAM word at the read pointer, and the read pointer then advances by one with the same wrap. A host write to address 5 loads the read pointer.
- R9: Status bit 3 (formatter empty) is 0 in the cycle after a frame is accepted, while that frame's RAM write is pending. It returns to 1 in the cycle after the write, if no new frame was accepted.
- R10: When full is set, the entry at the write pointer holds the oldest frame, so reading DEPTH words from there returns the frames in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | A trace frame is presented this cycle |
| frame_data | input | 32 | Trace frame word |
| trig_in | input | 1 | Trigger pulse |
| host_en | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |

## Verification
The hardest case to reach from the ports is a wrapped ring that is then stopped by the trigger countdown. In that case the oldest frame sits at a non-zero write pointer, and the read pointer must wrap while the buffer is drained. The stimulus stores more frames than DEPTH before it fires the trigger, so that both the full flag and the completion come from real traffic. It then sets the read pointer to the write pointer and drains exactly DEPTH words, which must come out in arrival order. The end of the countdown is checked by presenting extra frames after completion and confirming that the write pointer does not move.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } trc_state_e;

    localparam logic [3:0] A_IDENT = 4'd0;
    localparam logic [3:0] A_DEPTH = 4'd1;
    localparam logic [3:0] A_WIDTH = 4'd2;
    localparam logic [3:0] A_STAT  = 4'd3;
    localparam logic [3:0] A_DATA  = 4'd4;
    localparam logic [3:0] A_RPTR  = 4'd5;
    localparam logic [3:0] A_WPTR  = 4'd6;
    localparam logic [3:0] A_TCNT  = 4'd7;
    localparam logic [3:0] A_CTRL  = 4'd8;

    localparam int WORD_W = 32;
endpackage

// File: rtl/trc_ctrl_fsm.sv
module trc_ctrl_fsm
    import trc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_wdata,
    input  logic             tcnt_wr,
    input  logic [CNT_W-1:0] tcnt_wdata,
    input  logic             frame_valid,
    input  logic             trig_in,
    output trc_state_e       state,
    output logic             accept,
    output logic             triggered,
    output logic [1:0]       ctrl_q,
    output logic [CNT_W-1:0] tcnt
);
    trc_state_e st_q, st_d;
    logic       count_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d = ctrl_wdata[0] ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                end
                ST_ARMED: begin
                    if (trig_in) st_d = (tcnt == '0) ? ST_DONE : ST_POST;
                end
                ST_POST: begin
                    if (frame_valid && tcnt <= CNT_W'(1)) st_d = ST_DONE;
                end
                ST_DONE: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        accept   = frame_valid && (st_q == ST_ARMED || st_q == ST_POST);
        count_en = frame_valid && (st_q == ST_POST) && (tcnt != '0);
        state    = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            triggered <= 1'b0;
            ctrl_q    <= 2'b00;
        end else begin
            if (tcnt_wr)       tcnt <= tcnt_wdata;
            else if (count_en) tcnt <= tcnt - CNT_W'(1);

            if (ctrl_wr) begin
                ctrl_q <= ctrl_wdata;
                if (ctrl_wdata[0]) triggered <= 1'b0;
            end else if (st_q == ST_ARMED && trig_in) begin
                triggered <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trc_ring_store.sv
module trc_ring_store
    import trc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] frame_data,
    input  logic              wptr_wr,
    input  logic [AW-1:0]     wptr_wdata,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [AW-1:0]     wptr,
    output logic              full,
    output logic              fmt_empty
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic              pend_vld;
    logic [WORD_W-1:0] pend_data;
    logic              at_end;

    assign at_end    = (wptr == AW'(DEPTH - 1));
    assign fmt_empty = !pend_vld;
    assign rd_word   = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_data <= '0;
            wptr      <= '0;
            full      <= 1'b0;
        end else begin
            pend_vld  <= accept;
            pend_data <= frame_data;
            if (wptr_wr) begin
                wptr <= wptr_wdata;
                full <= 1'b0;
            end else if (pend_vld) begin
                wptr <= at_end ? '0 : wptr + AW'(1);
                if (at_end) full <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pend_vld) mem[wptr] <= pend_data;
    end
endmodule

// File: rtl/trc_host_regs.sv
module trc_host_regs
    import trc_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [31:0] ID_CODE = 32'h7A3C_0001,
    localparam int         AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [AW-1:0]     ptr_wdata,
    input  logic [3:0]        status,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [AW-1:0]     wptr,
    input  logic [WORD_W-1:0] tcnt,
    input  logic [1:0]        ctrl_q,
    output logic              wr_ctrl,
    output logic              wr_wptr,
    output logic              wr_tcnt,
    output logic              rd_data,
    output logic [AW-1:0]     rptr,
    output logic [WORD_W-1:0] host_rdata
);
    logic wr_rptr;

    always_comb begin
        wr_ctrl = host_en && host_wr && host_addr == A_CTRL;
        wr_wptr = host_en && host_wr && host_addr == A_WPTR;
        wr_tcnt = host_en && host_wr && host_addr == A_TCNT;
        wr_rptr = host_en && host_wr && host_addr == A_RPTR;
        rd_data = host_en && !host_wr && host_addr == A_DATA;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rptr <= '0;
        else if (wr_rptr) rptr <= ptr_wdata;
        else if (rd_data) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end

    always_comb begin
        case (host_addr)
            A_IDENT: host_rdata = ID_CODE;
            A_DEPTH: host_rdata = WORD_W'(DEPTH);
            A_WIDTH: host_rdata = WORD_W'(WORD_W);
            A_STAT:  host_rdata = {28'd0, status};
            A_DATA:  host_rdata = rd_word;
            A_RPTR:  host_rdata = {{(WORD_W-AW){1'b0}}, rptr};
            A_WPTR:  host_rdata = {{(WORD_W-AW){1'b0}}, wptr};
            A_TCNT:  host_rdata = tcnt;
            A_CTRL:  host_rdata = {30'd0, ctrl_q};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
    import trc_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [31:0] ID_CODE = 32'h7A3C_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_valid,
    input  logic [31:0] frame_data,
    input  logic        trig_in,
    input  logic        host_en,
    input  logic        host_wr,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);
    localparam int AW = $clog2(DEPTH);

    trc_state_e        state;
    logic              accept, triggered, full, fmt_empty;
    logic [1:0]        ctrl_q;
    logic [WORD_W-1:0] tcnt, rd_word;
    logic [AW-1:0]     wptr, rptr;
    logic              wr_ctrl, wr_wptr, wr_tcnt, rd_data;
    logic [3:0]        status;

    assign status = {fmt_empty, (state == ST_DONE), triggered, full};

    trc_ctrl_fsm #(.CNT_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_ctrl), .ctrl_wdata(host_wdata[1:0]),
        .tcnt_wr(wr_tcnt), .tcnt_wdata(host_wdata),
        .frame_valid(frame_valid), .trig_in(trig_in),
        .state(state), .accept(accept), .triggered(triggered),
        .ctrl_q(ctrl_q), .tcnt(tcnt)
    );

    trc_ring_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .frame_data(frame_data),
        .wptr_wr(wr_wptr), .wptr_wdata(host_wdata[AW-1:0]),
        .rd_addr(rptr), .rd_word(rd_word),
        .wptr(wptr), .full(full), .fmt_empty(fmt_empty)
    );

    trc_host_regs #(.DEPTH(DEPTH), .ID_CODE(ID_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_en(host_en), .host_wr(host_wr), .host_addr(host_addr),
        .ptr_wdata(host_wdata[AW-1:0]),
        .status(status), .rd_word(rd_word), .wptr(wptr),
        .tcnt(tcnt), .ctrl_q(ctrl_q),
        .wr_ctrl(wr_ctrl), .wr_wptr(wr_wptr), .wr_tcnt(wr_tcnt),
        .rd_data(rd_data), .rptr(rptr), .host_rdata(host_rdata)
    );
endmodule

// File: rtl/trc_ring_capture_chk.sv
module trc_ring_capture_chk
    import trc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input trc_state_e    state,
    input logic          accept,
    input logic          triggered,
    input logic          full,
    input logic          fmt_empty,
    input logic          wr_ctrl,
    input logic          wr_wptr,
    input logic          rd_data,
    input logic          host_wr,
    input logic          host_addr_rptr,
    input logic          trig_in,
    input logic [AW-1:0] rptr,
    input logic [AW-1:0] wptr
);
    // R4: nothing is taken in while idle or complete
    a_r4_drop_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DONE) |-> !accept);

    // R9: an accepted frame makes the formatter busy in the next cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !fmt_empty);

    // R7: full is sticky until the write pointer is written
    a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !wr_wptr) |=> full);

    // R6: completion holds until a control write
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !wr_ctrl) |=> state == ST_DONE);

    // R5: triggered flag is sticky
    a_r5_trig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !wr_ctrl) |=> triggered);

    // R5: a trigger outside ARMED does not raise the flag
    a_r5_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!triggered && state != ST_ARMED && !wr_ctrl) |=> !triggered);

    // R8: a data read moves the read pointer
    a_r8_rptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !(host_wr && host_addr_rptr)) |=> rptr != $past(rptr));

    // R4: write pointer stays put when no frame pending and no host write
    a_r4_wptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_empty && !wr_wptr) |=> $stable(wptr));

    // R5: trig_in seen in ARMED raises the flag next cycle
    a_r5_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && trig_in && !wr_ctrl) |=> triggered);
endmodule

bind trace_ring_capture trc_ring_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
    .triggered(triggered), .full(full), .fmt_empty(fmt_empty),
    .wr_ctrl(wr_ctrl), .wr_wptr(wr_wptr), .rd_data(rd_data),
    .host_wr(host_wr), .host_addr_rptr(host_addr == trc_pkg::A_RPTR),
    .trig_in(trig_in), .rptr(rptr), .wptr(wptr)
);

// File: tb/sim_trace_ring_capture.sv
`timescale 1ns/1ps
module sim_trace_ring_capture;
    localparam int          DEPTH = 64;
    localparam logic [31:0] IDC   = 32'h7A3C_0001;
    localparam time         TCLK  = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_data = '0;
    logic        trig_in = 1'b0;
    logic        host_en = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    trace_ring_capture #(.DEPTH(DEPTH), .ID_CODE(IDC)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_data(frame_data), .trig_in(trig_in), .host_en(host_en),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        host_en = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 0; host_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        host_en = 1; host_wr = 0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_en = 0;
    endtask

    task automatic push(input logic [31:0] d, input logic t);
        frame_valid = 1; frame_data = d; trig_in = t;
        @(negedge clk);
        frame_valid = 0; trig_in = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); check("R1 ident", v, IDC);
        rd(4'd1, v); check("R1 depth", v, 32'(DEPTH));
        rd(4'd2, v); check("R1 width", v, 32'd32);
        rd(4'd3, v); check("R2 status", v, 32'd8);
        rd(4'd6, v); check("R2 wptr", v, 0);
        rd(4'd5, v); check("R2 rptr", v, 0);
        rd(4'd8, v); check("R2 ctrl", v, 0);
        rd(4'd12, v); check("R1 unused addr", v, 0);
    endtask

    task automatic t_linear();
        logic [31:0] v;
        wr(4'd7, 32'd3); wr(4'd6, 0); wr(4'd8, 32'd1);
        push(32'hA000_0000, 0);
        rd(4'd3, v); check("R9 busy after accept", v[3], 1'b0);
        rd(4'd3, v); check("R9 empty again", v, 32'd8);
        for (int i = 1; i < 5; i++) push(32'hA000_0000 + i, 0);
        idle(1);
        rd(4'd3, v); check("R5 untriggered status", v, 32'd8);
        push(32'hA000_0005, 1);
        push(32'hA000_0006, 0);
        rd(4'd7, v); check("R6 counter after one post frame", v, 32'd2);
        push(32'hA000_0007, 0);
        push(32'hA000_0008, 0);
        push(32'hA000_0009, 0);
        push(32'hA000_000A, 0);
        idle(1);
        rd(4'd3, v); check("R6 complete status", v, 32'd14);
        rd(4'd6, v); check("R4 R6 wptr after stop", v, 32'd9);
        wr(4'd5, 0);
        for (int i = 0; i < 9; i++) begin
            rd(4'd4, v); check("R8 linear data", v, 32'hA000_0000 + i);
        end
        rd(4'd5, v); check("R8 rptr advanced", v, 32'd9);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(4'd7, 32'd2); wr(4'd6, 0); wr(4'd8, 32'd1);
        for (int i = 0; i < DEPTH + 6; i++) push(32'hB000_0000 + i, 0);
        idle(1);
        rd(4'd3, v); check("R7 full after wrap", v, 32'd9);
        rd(4'd6, v); check("R7 wptr wrapped", v, 32'd6);
        push(32'hB000_0000 + DEPTH + 6, 1);
        push(32'hB000_0000 + DEPTH + 7, 0);
        push(32'hB000_0000 + DEPTH + 8, 0);
        push(32'hDEAD_0000, 0);
        idle(1);
        rd(4'd3, v); check("R6 R7 complete and full", v, 32'd15);
        rd(4'd6, v); check("R4 wptr frozen", v, 32'd9);
        wr(4'd5, 32'd9);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd4, v); check("R10 oldest-first drain", v, 32'hB000_0009 + i);
        end
        rd(4'd5, v); check("R8 rptr wrapped", v, 32'd9);
        wr(4'd6, 0);
        rd(4'd3, v); check("R7 full cleared", v[0], 1'b0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(4'd7, 32'd5); wr(4'd8, 32'd1);
        push(32'hC000_0000, 0); push(32'hC000_0001, 0);
        wr(4'd8, 0);
        push(32'hC000_0002, 0); push(32'hC000_0003, 0);
        trig_in = 1; @(negedge clk); trig_in = 0;
        idle(1);
        rd(4'd6, v); check("R4 idle drops frames", v, 32'd2);
        rd(4'd3, v); check("R5 trigger ignored when idle", v, 32'd8);
        rd(4'd8, v); check("R3 ctrl stopped", v, 0);
        wr(4'd8, 32'd3);
        rd(4'd8, v); check("R3 ctrl readback", v, 32'd3);
        wr(4'd8, 0);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        wr(4'd6, 0); wr(4'd7, 0); wr(4'd8, 32'd1);
        push(32'hE000_0001, 1);
        push(32'hE000_0002, 0);
        idle(1);
        rd(4'd6, v); check("R6 zero count stores trigger frame only", v, 32'd1);
        rd(4'd3, v); check("R6 zero count complete", v, 32'd14);
        wr(4'd5, 0);
        rd(4'd4, v); check("R6 trigger frame content", v, 32'hE000_0001);
        wr(4'd8, 32'd1);
        rd(4'd3, v); check("R3 enable clears triggered", v, 32'd8);
        wr(4'd8, 0);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1;
        idle(1);
        t_reset();
        t_linear();
        t_wrap();
        t_stop();
        t_zero_count();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule